// File: doc/BRIEF.md
# Serial ADC Sample Capture Master

This block drives a three-wire link to a 12-bit serial analog-to-digital converter. It generates an active-low chip-select and a serial clock, and it samples the converter's serial data line. A one-cycle start pulse begins a conversion frame. While chip-select is low the block clocks in sixteen bits, MSB first. The first four bits must be zero. The last twelve carry the converted sample.

When a frame ends, the block raises chip-select and holds it high for one full serial clock period. It then delivers the result with a one-cycle valid strobe. The result comes in two forms: the raw 12-bit sample, and a 16-bit word sign-extended from the top sample bit. If any of the leading bits reads as one, a framing-error flag is raised next to the sample, and the sample is still delivered. The serial clock is the system clock divided by an even ratio, set by a parameter.

Top module: `adc_sample_capture`

## Requirements
- R1: While the synchronous active-high reset is applied and in the first cycle after it, chip-select is high, the serial clock is low, valid is low and busy is low.
- R2: A start pulse seen while busy is low drives chip-select low and busy high on the next clock edge. Chip-select then stays low for exactly 16 serial clock periods.
- R3: The serial clock has a period of DIV system cycles, with DIV/2 cycles high and DIV/2 low. Each frame has exactly 16 rising edges. The serial clock is low whenever chip-select is high.
- R4: One data bit is sampled on each rising serial clock edge, MSB first. The first four bits received are the leading bits. The fifth bit received becomes sample bit 11 and the sixteenth becomes sample bit 0.
- R5: The framing-error output, updated together with valid, is 1 when any of the four leading bits was 1 and 0 otherwise. The sample is delivered in either case.
- R6: The 16-bit word output holds sample bit 11 in bits 15 to 12 and the 12 sample bits in bits 11 to 0.
- R7: Valid is a one-cycle pulse, 17*DIV system cycles after the edge that accepted the start pulse. Busy is low in that same cycle.
- R8: Between two frames, chip-select stays high for at least DIV system cycles.
- R9: A start pulse that arrives while busy is high is ignored. It produces no extra frame and no extra valid.
- R10: The sample, word and framing-error outputs hold their values in every cycle in which valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request pulse |
| adc_sdata_i | input | 1 | Serial data from the converter |
| adc_cs_n_o | output | 1 | Active-low chip-select |
| adc_sclk_o | output | 1 | Serial clock, idle low |
| busy_o | output | 1 | High from the accepted start until the valid strobe |
| sample_valid_o | output | 1 | One-cycle result strobe |
| frame_err_o | output | 1 | A leading bit of the last frame was 1 |
| sample_o | output | 12 | Raw 12-bit sample |
| word_o | output | 16 | Sign-extended sample |

## Verification
Chip-select falls and busy rises one edge after the start is accepted. Each serial clock edge falls on a multiple of DIV/2 cycles after that edge. The valid strobe follows 17*DIV cycles after it: 16 frame periods plus one gap period. The driver records the cycle count just after the accepting edge and pushes the expected result into a queue. The monitor samples every output on the falling system clock, compares when valid appears, and requires the measured latency to equal 17*DIV exactly. The serial clock period, the rising-edge count, the chip-select low time and the gap between frames are measured at the same half-cycle offset, so no check depends on the order of events at a clock edge.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
   typedef enum logic [1:0] {
      CAP_IDLE  = 2'd0,
      CAP_SHIFT = 2'd1,
      CAP_GAP   = 2'd2
   } cap_state_e;
endpackage

// File: rtl/adc_sclk_gen.sv
// Divided serial clock: toggles every DIV/2 system cycles while run is high,
// parked low otherwise. rise_now/fall_now flag the edge that makes it toggle.
module adc_sclk_gen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic sclk,
   output logic rise_now,
   output logic fall_now
);
   localparam int HALF = DIV / 2;

   logic tick;

   generate
      if (HALF == 1) begin : g_fast
         assign tick = run;
      end else begin : g_count
         localparam int HW = $clog2(HALF);
         logic [HW-1:0] hcnt;
         always_ff @(posedge clk) begin
            if (rst || !run) begin
               hcnt <= '0;
            end else if (hcnt == HW'(HALF - 1)) begin
               hcnt <= '0;
            end else begin
               hcnt <= hcnt + 1'b1;
            end
         end
         assign tick = run && (hcnt == HW'(HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         sclk <= 1'b0;
      end else if (tick) begin
         sclk <= ~sclk;
      end
   end

   assign rise_now = tick && !sclk;
   assign fall_now = tick && sclk;
endmodule

// File: rtl/adc_frame_shift.sv
// Frame shift register with bit counter and leading-bit check.
module adc_frame_shift #(
   parameter int LEAD = 4,
   parameter int SAMP = 12
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            clear,
   input  logic            shift_en,
   input  logic            sdata,
   output logic            all_bits,
   output logic            lead_err,
   output logic [SAMP-1:0] sample
);
   localparam int FRAME = LEAD + SAMP;
   localparam int CW    = $clog2(FRAME + 1);

   logic [FRAME-1:0] shreg;
   logic [CW-1:0]    nbits;

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         shreg <= '0;
         nbits <= '0;
      end else if (shift_en) begin
         shreg <= {shreg[FRAME-2:0], sdata};
         nbits <= nbits + 1'b1;
      end
   end

   assign all_bits = (nbits == CW'(FRAME));
   assign lead_err = |shreg[FRAME-1 -: LEAD];
   assign sample   = shreg[SAMP-1:0];
endmodule

// File: rtl/adc_sample_format.sv
// Widens the sample to the output word, sign- or zero-extended.
module adc_sample_format #(
   parameter int SAMP     = 12,
   parameter int OUT_W    = 16,
   parameter bit SIGN_EXT = 1'b1
) (
   input  logic [SAMP-1:0]  sample,
   output logic [OUT_W-1:0] word
);
   localparam int EXT = OUT_W - SAMP;

   generate
      if (EXT == 0) begin : g_same
         assign word = sample;
      end else if (SIGN_EXT) begin : g_sign
         assign word = {{EXT{sample[SAMP-1]}}, sample};
      end else begin : g_zero
         assign word = {{EXT{1'b0}}, sample};
      end
   endgenerate
endmodule

// File: rtl/adc_sample_capture.sv
module adc_sample_capture #(
   parameter int DIV      = 4,
   parameter int LEAD     = 4,
   parameter int SAMP     = 12,
   parameter int OUT_W    = 16,
   parameter bit SIGN_EXT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic             adc_sdata_i,
   output logic             adc_cs_n_o,
   output logic             adc_sclk_o,
   output logic             busy_o,
   output logic             sample_valid_o,
   output logic             frame_err_o,
   output logic [SAMP-1:0]  sample_o,
   output logic [OUT_W-1:0] word_o
);
   import adc_cap_pkg::*;

   localparam int GW = $clog2(DIV);

   generate
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("adc_sample_capture: DIV must be even and at least 2");
      end
      if (OUT_W < SAMP) begin : g_bad_width
         $error("adc_sample_capture: OUT_W must not be below SAMP");
      end
      if (LEAD < 1 || SAMP < 2) begin : g_bad_frame
         $error("adc_sample_capture: LEAD >= 1 and SAMP >= 2 required");
      end
   endgenerate

   cap_state_e      state;
   logic [GW-1:0]   gcnt;
   logic            accept;
   logic            run;
   logic            rise_now, fall_now;
   logic            all_bits, lead_err;
   logic [SAMP-1:0] sample_w;
   logic [OUT_W-1:0] word_w;
   logic            gap_done;

   assign accept   = (state == CAP_IDLE) && start_i;
   assign run      = (state == CAP_SHIFT);
   assign gap_done = (state == CAP_GAP) && (gcnt == GW'(DIV - 1));

   adc_sclk_gen #(.DIV(DIV)) u_sclk (
      .clk      (clk),
      .rst      (rst),
      .run      (run),
      .sclk     (adc_sclk_o),
      .rise_now (rise_now),
      .fall_now (fall_now)
   );

   adc_frame_shift #(.LEAD(LEAD), .SAMP(SAMP)) u_shift (
      .clk      (clk),
      .rst      (rst),
      .clear    (accept),
      .shift_en (rise_now),
      .sdata    (adc_sdata_i),
      .all_bits (all_bits),
      .lead_err (lead_err),
      .sample   (sample_w)
   );

   adc_sample_format #(.SAMP(SAMP), .OUT_W(OUT_W), .SIGN_EXT(SIGN_EXT)) u_fmt (
      .sample (sample_w),
      .word   (word_w)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state      <= CAP_IDLE;
         gcnt       <= '0;
         adc_cs_n_o <= 1'b1;
      end else begin
         unique case (state)
            CAP_IDLE: begin
               gcnt <= '0;
               if (start_i) begin
                  state      <= CAP_SHIFT;
                  adc_cs_n_o <= 1'b0;
               end
            end
            CAP_SHIFT: begin
               if (fall_now && all_bits) begin
                  state      <= CAP_GAP;
                  adc_cs_n_o <= 1'b1;
                  gcnt       <= '0;
               end
            end
            CAP_GAP: begin
               if (gap_done) begin
                  state <= CAP_IDLE;
               end else begin
                  gcnt <= gcnt + 1'b1;
               end
            end
            default: begin
               state      <= CAP_IDLE;
               adc_cs_n_o <= 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_o <= 1'b0;
      end else if (accept) begin
         busy_o <= 1'b1;
      end else if (gap_done) begin
         busy_o <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sample_valid_o <= 1'b0;
         frame_err_o    <= 1'b0;
         sample_o       <= '0;
         word_o         <= '0;
      end else begin
         sample_valid_o <= gap_done;
         if (gap_done) begin
            frame_err_o <= lead_err;
            sample_o    <= sample_w;
            word_o      <= word_w;
         end
      end
   end
endmodule

// File: rtl/adc_capture_chk.sv
module adc_capture_chk #(
   parameter int DIV   = 4,
   parameter int LEAD  = 4,
   parameter int SAMP  = 12,
   parameter int OUT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             start_i,
   input logic             adc_cs_n_o,
   input logic             adc_sclk_o,
   input logic             busy_o,
   input logic             sample_valid_o,
   input logic             frame_err_o,
   input logic [SAMP-1:0]  sample_o,
   input logic [OUT_W-1:0] word_o
);
   localparam int FRAME = LEAD + SAMP;
   localparam int RW    = $clog2(FRAME + 2);
   localparam int HW    = $clog2(DIV + 1);

   logic          sclk_d, cs_d, seen;
   logic [RW-1:0] rise_cnt;
   logic [HW-1:0] hi_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         sclk_d   <= 1'b0;
         cs_d     <= 1'b1;
         seen     <= 1'b0;
         rise_cnt <= '0;
         hi_cnt   <= '0;
      end else begin
         sclk_d <= adc_sclk_o;
         cs_d   <= adc_cs_n_o;
         if (!adc_cs_n_o) seen <= 1'b1;
         if (!adc_cs_n_o && adc_sclk_o && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
         else if (adc_cs_n_o && cs_d) rise_cnt <= '0;
         if (!adc_cs_n_o) hi_cnt <= '0;
         else if (hi_cnt < HW'(DIV)) hi_cnt <= hi_cnt + 1'b1;
      end
   end

   a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (adc_cs_n_o && !adc_sclk_o && !sample_valid_o && !busy_o));

   a_r2_start_opens: assert property (@(posedge clk) disable iff (rst)
      (start_i && !busy_o) |=> (!adc_cs_n_o && busy_o));

   a_r3_sclk_parked: assert property (@(posedge clk) disable iff (rst)
      adc_cs_n_o |-> !adc_sclk_o);

   a_r3_rise_count: assert property (@(posedge clk) disable iff (rst)
      $rose(adc_cs_n_o) |-> (rise_cnt == RW'(FRAME)));

   a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
      sample_valid_o |=> !sample_valid_o);

   a_r7_busy_released: assert property (@(posedge clk) disable iff (rst)
      sample_valid_o |-> !busy_o);

   a_r8_gap_length: assert property (@(posedge clk) disable iff (rst)
      ($fell(adc_cs_n_o) && seen) |-> (hi_cnt >= HW'(DIV)));

   a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
      (busy_o && !adc_cs_n_o) |=> (busy_o || sample_valid_o));

   a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      !sample_valid_o |-> ($stable(word_o) && $stable(sample_o) && $stable(frame_err_o)));
endmodule

bind adc_sample_capture adc_capture_chk #(
   .DIV(DIV), .LEAD(LEAD), .SAMP(SAMP), .OUT_W(OUT_W)
) u_chk (
   .clk            (clk),
   .rst            (rst),
   .start_i        (start_i),
   .adc_cs_n_o     (adc_cs_n_o),
   .adc_sclk_o     (adc_sclk_o),
   .busy_o         (busy_o),
   .sample_valid_o (sample_valid_o),
   .frame_err_o    (frame_err_o),
   .sample_o       (sample_o),
   .word_o         (word_o)
);

// File: tb/adc_sample_capture_tb.sv
module adc_sample_capture_tb;
   localparam int DIV = 4;
   localparam int LAT = 17 * DIV;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start_i = 1'b0;
   logic        adc_sdata_i = 1'b0;
   logic        adc_cs_n_o, adc_sclk_o, busy_o, sample_valid_o, frame_err_o;
   logic [11:0] sample_o;
   logic [15:0] word_o;

   always #2 clk = ~clk;

   adc_sample_capture #(.DIV(DIV)) u_dut (
      .clk            (clk),
      .rst            (rst),
      .start_i        (start_i),
      .adc_sdata_i    (adc_sdata_i),
      .adc_cs_n_o     (adc_cs_n_o),
      .adc_sclk_o     (adc_sclk_o),
      .busy_o         (busy_o),
      .sample_valid_o (sample_valid_o),
      .frame_err_o    (frame_err_o),
      .sample_o       (sample_o),
      .word_o         (word_o)
   );

   typedef struct {
      logic [15:0] word;
      logic [11:0] samp;
      logic        err;
      int          t0;
   } exp_t;

   exp_t        sb[$];
   int          n_vec = 0;
   int          n_bad = 0;
   int          cyc = 0;
   logic [15:0] frame_bits = '0;
   int          bit_i = 0;
   bit          finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   // converter model: first bit on chip-select fall, next bit on each sclk fall
   initial forever begin
      @(negedge adc_cs_n_o);
      bit_i       = 15;
      adc_sdata_i = frame_bits[15];
   end
   initial forever begin
      @(negedge adc_sclk_o);
      if (bit_i > 0) begin
         bit_i       = bit_i - 1;
         adc_sdata_i = frame_bits[bit_i];
      end
   end

   // driver: waits for idle, pushes the expected result, pulses start
   task automatic send(input logic [15:0] f);
      exp_t e;
      while (busy_o) @(negedge clk);
      frame_bits = f;
      e.samp = f[11:0];
      e.word = {{4{f[11]}}, f[11:0]};
      e.err  = |f[15:12];
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      e.t0 = cyc;
      sb.push_back(e);
      check("R2 cs_n low after start", {31'd0, adc_cs_n_o}, 32'd0);
      check("R2 busy after start", {31'd0, busy_o}, 32'd1);
   endtask

   // monitor: samples at the falling system edge
   logic [15:0] last_word = '0;
   logic [11:0] last_samp = '0;
   logic        last_err = 1'b0;
   logic        sclk_p = 1'b0, cs_p = 1'b1, frame_seen = 1'b0;
   int          rise_t = -1, rises = 0, cs_fall_t = 0, cs_rise_t = 0;

   always @(negedge clk) begin
      if (!rst) begin
         if (sample_valid_o) begin
            if (sb.size() == 0) begin
               check("R9 unexpected valid", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check("R4 sample bits", {20'd0, sample_o}, {20'd0, e.samp});
               check("R6 sign-extended word", {16'd0, word_o}, {16'd0, e.word});
               check("R5 framing error", {31'd0, frame_err_o}, {31'd0, e.err});
               check("R7 valid latency", cyc - e.t0, LAT);
               check("R7 busy low at valid", {31'd0, busy_o}, 32'd0);
            end
            last_word = word_o;
            last_samp = sample_o;
            last_err  = frame_err_o;
         end else begin
            if (word_o !== last_word || sample_o !== last_samp || frame_err_o !== last_err)
               check("R10 outputs hold", {4'd0, sample_o, word_o}, {4'd0, last_samp, last_word});
         end
         if (adc_cs_n_o && adc_sclk_o) check("R3 sclk low while deselected", 32'd1, 32'd0);
         if (!adc_cs_n_o && cs_p) begin
            if (frame_seen) check("R8 deselect gap", (cyc - cs_rise_t >= DIV) ? 1 : 0, 32'd1);
            cs_fall_t  = cyc;
            frame_seen = 1'b1;
            rises      = 0;
            rise_t     = -1;
         end
         if (!adc_cs_n_o && adc_sclk_o && !sclk_p) begin
            if (rise_t >= 0) check("R3 sclk period", cyc - rise_t, DIV);
            else check("R3 first rise offset", cyc - cs_fall_t, DIV / 2);
            rise_t = cyc;
            rises++;
         end
         if (adc_cs_n_o && !cs_p) begin
            check("R3 rising edges per frame", rises, 16);
            check("R2 cs_n low time", cyc - cs_fall_t, 16 * DIV);
            cs_rise_t = cyc;
         end
         sclk_p = adc_sclk_o;
         cs_p   = adc_cs_n_o;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 cs_n in reset", {31'd0, adc_cs_n_o}, 32'd1);
      check("R1 sclk in reset", {31'd0, adc_sclk_o}, 32'd0);
      check("R1 valid in reset", {31'd0, sample_valid_o}, 32'd0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 cs_n after reset", {31'd0, adc_cs_n_o}, 32'd1);
      check("R1 busy after reset", {31'd0, busy_o}, 32'd0);
      repeat (3) @(negedge clk);

      send(16'h0ABC);
      send(16'h07FF);
      send(16'h0800);
      send(16'h0000);
      send(16'h0FFF);
      send(16'h8123);   // R5 leading bit set
      send(16'hF555);   // R5 all leading bits set
      send(16'h1001);   // R5 last leading bit only

      // R9: start pulses mid-frame are ignored
      send(16'h0456);
      repeat (5 * DIV) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (3 * DIV) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (busy_o) @(negedge clk);
      repeat (30 * DIV) @(negedge clk);
      check("R9 no extra frame: cs_n", {31'd0, adc_cs_n_o}, 32'd1);
      check("R9 no extra frame: busy", {31'd0, busy_o}, 32'd0);

      send(16'h0321);
      while (busy_o) @(negedge clk);
      repeat (4 * DIV) @(negedge clk);
      check("R9 queue drained", sb.size(), 0);
      finished = 1'b1;
      summary();
   end
endmodule